// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns a fixed 48 MHz reference into a one-cycle enable that fires sixteen times per serial bit. The spacing between enables comes from a divisor made of a whole part and a fraction in eighths. A whole divisor would give only coarse rate steps. To avoid that, the block lets most periods run the whole-part length and stretches some of them by one reference cycle. Over every eight periods the average spacing then equals the programmed divisor exactly. With a 14-bit whole part and the default 48 MHz reference, the resulting rate range runs from about 183 baud up to 3 Mbaud.

A host writes a new divisor through a one-cycle load strobe at any time. The value waits in a pending register. It is picked up only when the running period ends, so a period is never cut short or glitched. Two states control the sequence. `ST_PRIME` is entered at reset. Its only transition, "prime", fires on the first clock edge after reset and moves to `ST_RUN`, loading the first full period. In `ST_RUN`, the transition "count" decrements the period counter. The transition "reload" is taken when the counter reaches zero: it raises the enable and starts the next period from the pending divisor.

Top module: `baud_frac_gen`

## Requirements
- R1: While reset is asserted the enable output `tick` is low. Reset clears the period counter and the fraction accumulator, and sets the pending divisor to the parameter values `RST_INT` and `RST_FRAC`.
- R2: After reset is released, the first `tick` appears after exactly one full period of L reference cycles, counted from the first clock edge with reset released. L is the length given by the reset divisor. No enable appears earlier.
- R3: With a fraction of zero and a whole part I ≥ 1, consecutive ticks are exactly I reference cycles apart.
- R4: At the start of each period, the 3-bit fraction (in eighths) is added to a 3-bit accumulator that starts at zero after reset. When the sum carries out of bit 2, that period lasts I+1 cycles instead of I. The accumulator keeps the low 3 bits of the sum.
- R5: A whole part of 1 with a fraction of 0 gives a tick on every reference cycle (3 Mbaud at 48 MHz).
- R6: A whole part of 0 is treated as 1.
- R7: A divisor loaded with `ld_valid` never changes the period in progress; it governs the period that starts at the next terminal count. A load sampled on the same edge as a terminal count takes effect one period later.
- R8: When several loads arrive within one period, only the last one governs the following period.
- R9: Loading a new divisor does not clear the fraction accumulator; the dithering pattern continues from where it was.
- R10: A tick is high for one cycle only, unless the period in effect is one cycle long.
- R11: The largest divisor (all ones in both fields) gives periods of 2^INT_W − 1 or 2^INT_W cycles, following R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (48 MHz nominal) |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | One-cycle strobe that captures a new divisor into the pending register |
| ld_int | input | INT_W | Whole part of the divisor |
| ld_frac | input | FRAC_W | Fractional part of the divisor, in eighths |
| tick | output | 1 | 16x baud enable, high for one reference cycle per period |

## Verification
The bench builds the block with `INT_W` = 14 and `FRAC_W` = 3 left at their defaults, so the full-scale divisor of 16383 and 7/8 can be reached and its long periods measured. The reset divisor is set to 6 and 2/8, which keeps the reset-to-first-tick interval short. Because the reset fraction is nonzero, the accumulator already holds a value when the first explicit load arrives, so the continuity of dithering across divisor changes is exercised. Loads are placed on terminal-count edges, in mid-period and back to back, to confirm when a new divisor takes effect.

// File: rtl/baud_pkg.sv
package baud_pkg;

    typedef enum logic {
        ST_PRIME = 1'b0,
        ST_RUN   = 1'b1
    } bg_state_t;

endpackage

// File: rtl/baud_div_reg.sv
module baud_div_reg #(
    parameter int INT_W    = 14,
    parameter int FRAC_W   = 3,
    parameter int RST_INT  = 26,
    parameter int RST_FRAC = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [INT_W-1:0]  ld_int,
    input  logic [FRAC_W-1:0] ld_frac,
    output logic [INT_W-1:0]  pend_int,
    output logic [FRAC_W-1:0] pend_frac,
    output logic [INT_W-1:0]  eff_int
);

    localparam logic [INT_W-1:0]  RV_INT  = INT_W'(RST_INT);
    localparam logic [FRAC_W-1:0] RV_FRAC = FRAC_W'(RST_FRAC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_int  <= RV_INT;
            pend_frac <= RV_FRAC;
        end else if (ld_valid) begin
            pend_int  <= ld_int;
            pend_frac <= ld_frac;
        end
    end

    // a zero whole part is promoted to one
    always_comb begin
        eff_int = (pend_int == '0) ? INT_W'(1) : pend_int;
    end

endmodule

// File: rtl/baud_frac_acc.sv
module baud_frac_acc #(
    parameter int FRAC_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [FRAC_W-1:0] frac,
    output logic              stretch,
    output logic [FRAC_W-1:0] acc_o
);

    logic [FRAC_W:0] sum;

    always_comb begin
        sum     = {1'b0, acc_o} + {1'b0, frac};
        stretch = sum[FRAC_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_o <= '0;
        end else if (step) begin
            acc_o <= sum[FRAC_W-1:0];
        end
    end

endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen
    import baud_pkg::*;
#(
    parameter int INT_W    = 14,
    parameter int FRAC_W   = 3,
    parameter int RST_INT  = 26,
    parameter int RST_FRAC = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [INT_W-1:0]  ld_int,
    input  logic [FRAC_W-1:0] ld_frac,
    output logic              tick
);

    localparam int CNT_W = INT_W + 1;

    bg_state_t         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  period_len;
    logic [INT_W-1:0]  pend_int;
    logic [FRAC_W-1:0] pend_frac;
    logic [INT_W-1:0]  eff_int;
    logic [FRAC_W-1:0] acc_q;
    logic              stretch;
    logic              running;
    logic              reload;

    baud_div_reg #(
        .INT_W    (INT_W),
        .FRAC_W   (FRAC_W),
        .RST_INT  (RST_INT),
        .RST_FRAC (RST_FRAC)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_valid  (ld_valid),
        .ld_int    (ld_int),
        .ld_frac   (ld_frac),
        .pend_int  (pend_int),
        .pend_frac (pend_frac),
        .eff_int   (eff_int)
    );

    baud_frac_acc #(
        .FRAC_W (FRAC_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (reload),
        .frac    (pend_frac),
        .stretch (stretch),
        .acc_o   (acc_q)
    );

    assign period_len = {1'b0, eff_int} + CNT_W'(stretch);
    assign running    = (state_q == ST_RUN);

    // next-state and reload decision
    always_comb begin
        state_d = state_q;
        reload  = 1'b0;
        unique case (state_q)
            ST_PRIME: begin
                reload  = 1'b1;
                state_d = ST_RUN;
            end
            ST_RUN: begin
                reload = (cnt_q == '0);
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PRIME;
        end else begin
            state_q <= state_d;
        end
    end

    // period counter: loads length-1, counts down to zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (reload) begin
            cnt_q <= period_len - CNT_W'(1);
        end else begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // output
    always_comb begin
        tick = 1'b0;
        unique case (state_q)
            ST_PRIME: tick = 1'b0;
            ST_RUN:   tick = (cnt_q == '0);
        endcase
    end

endmodule

// File: rtl/baud_frac_gen_chk.sv
module baud_frac_gen_chk #(
    parameter int INT_W  = 14,
    parameter int FRAC_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              running,
    input logic              ld_valid,
    input logic [INT_W-1:0]  ld_int,
    input logic [FRAC_W-1:0] ld_frac,
    input logic [INT_W-1:0]  pend_int,
    input logic [FRAC_W-1:0] pend_frac,
    input logic [FRAC_W-1:0] acc_q,
    input logic [INT_W:0]    cnt_q
);

    localparam int GAP_MAX = 2 ** INT_W;

    logic [INT_W+1:0] since_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_tick <= '0;
        else if (tick) since_tick <= '0;
        else since_tick <= since_tick + 1'b1;
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            assert_quiet_in_reset_R1: assert (!tick);
        end
    end

    assert_no_tick_at_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !tick);

    assert_cnt_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !tick) |=> (cnt_q == $past(cnt_q) - 1'b1));

    assert_acc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !tick) |=> $stable(acc_q));

    assert_load_captured_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> (pend_int == $past(ld_int) && pend_frac == $past(ld_frac)));

    assert_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && $past(tick)) |-> ($past(pend_int) <= 1));

    assert_gap_bounded_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |-> (since_tick < (INT_W+2)'(GAP_MAX)));

endmodule

bind baud_frac_gen baud_frac_gen_chk #(
    .INT_W  (INT_W),
    .FRAC_W (FRAC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .running   (running),
    .ld_valid  (ld_valid),
    .ld_int    (ld_int),
    .ld_frac   (ld_frac),
    .pend_int  (pend_int),
    .pend_frac (pend_frac),
    .acc_q     (acc_q),
    .cnt_q     (cnt_q)
);

// File: tb/tb_baud_frac_gen.sv
module tb_baud_frac_gen;

    localparam int CLK_P    = 10;
    localparam int INT_W    = 14;
    localparam int FRAC_W   = 3;
    localparam int RST_INT  = 6;
    localparam int RST_FRAC = 2;
    localparam int NV       = 8;
    localparam int GAP_LIM  = 40000;

    // vector table: whole part, fraction, periods to observe
    localparam int V_INT [NV] = '{4, 1, 5, 2, 0, 7, 3, 1};
    localparam int V_FRAC[NV] = '{0, 0, 3, 7, 0, 4, 1, 7};
    localparam int V_N   [NV] = '{6, 10, 16, 16, 4, 8, 8, 16};
    string v_tag[NV] = '{"R3", "R5", "R4", "R9", "R6", "R4", "R9", "R10"};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ld_valid = 1'b0;
    logic [INT_W-1:0]  ld_int = '0;
    logic [FRAC_W-1:0] ld_frac = '0;
    logic              tick;

    int    checks = 0;
    int    errors = 0;
    int    m_pend_i, m_pend_f, m_acc, exp_len, gap;
    bit    seen;
    string tag = "R2";

    always #(CLK_P/2) clk = ~clk;

    baud_frac_gen #(
        .INT_W    (INT_W),
        .FRAC_W   (FRAC_W),
        .RST_INT  (RST_INT),
        .RST_FRAC (RST_FRAC)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_valid (ld_valid),
        .ld_int   (ld_int),
        .ld_frac  (ld_frac),
        .tick     (tick)
    );

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // next period length from the pending divisor (R4, R6)
    task automatic start_period();
        int w;
        int s;
        w = (m_pend_i == 0) ? 1 : m_pend_i;
        s = m_acc + m_pend_f;
        m_acc = s % 8;
        exp_len = w + ((s >= 8) ? 1 : 0);
    endtask

    task automatic model_reset();
        m_pend_i = RST_INT;
        m_pend_f = RST_FRAC;
        m_acc    = 0;
        gap      = 0;
        start_period();
    endtask

    task automatic step();
        @(negedge clk);
        seen = 1'b0;
        if (!rst_n) begin
            checks++;
            if (tick !== 1'b0) begin
                errors++;
                $display("FAIL R1: tick=%0b in reset, expected 0", tick);
            end
        end else begin
            gap++;
            if (tick === 1'b1) begin
                seen = 1'b1;
                checks++;
                if (gap != exp_len) begin
                    errors++;
                    $display("FAIL %s: tick interval %0d, expected %0d", tag, gap, exp_len);
                end
                start_period();
                gap = 0;
            end else if (gap >= exp_len) begin
                checks++;
                errors++;
                $display("FAIL %s: no tick after %0d cycles, expected %0d", tag, gap, exp_len);
                start_period();
                gap = 0;
            end
        end
    endtask

    task automatic wait_tick();
        int guard;
        guard = 0;
        do begin
            step();
            guard++;
            if (guard > GAP_LIM) begin
                checks++;
                errors++;
                $display("FAIL %s: watchdog, %0d cycles, expected tick", tag, guard);
                summary();
            end
        end while (!seen);
    endtask

    task automatic load(input int wi, input int fr);
        ld_valid = 1'b1;
        ld_int   = INT_W'(wi);
        ld_frac  = FRAC_W'(fr);
        m_pend_i = wi;
        m_pend_f = fr;
        step();
        ld_valid = 1'b0;
    endtask

    initial begin
        #(CLK_P * 190000);
        checks++;
        errors++;
        $display("FAIL watchdog: run time exceeded, expected completion");
        summary();
    end

    initial begin
        // R1: quiet under reset
        repeat (4) step();
        rst_n = 1'b1;
        model_reset();
        // R2: first tick one full period after release
        tag = "R2";
        wait_tick();
        tag = "R3";
        wait_tick();

        // table walk; each load lands on a terminal-count edge (R7)
        for (int i = 0; i < NV; i++) begin
            tag = v_tag[i];
            wait_tick();
            load(V_INT[i], V_FRAC[i]);
            for (int k = 0; k < V_N[i]; k++) wait_tick();
        end

        // R7: load in mid-period leaves the current period intact
        tag = "R7";
        wait_tick();
        load(9, 0);
        repeat (3) step();
        load(4, 0);
        repeat (4) wait_tick();

        // R8: last of several loads in one period wins
        tag = "R8";
        wait_tick();
        step();
        load(11, 0);
        step();
        load(3, 5);
        repeat (10) wait_tick();

        // R11: full-scale divisor
        tag = "R11";
        wait_tick();
        load(16383, 7);
        repeat (3) wait_tick();
        load(2, 0);
        repeat (3) wait_tick();

        // R1: reset in mid-period, then R2 again
        repeat (1) step();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        model_reset();
        tag = "R2";
        wait_tick();
        tag = "R4";
        repeat (8) wait_tick();

        summary();
    end

endmodule